// File: doc/BRIEF.md
# Traffic Burst Detector with Triggered Capture

This block sits beside a packet stream and watches for sudden surges of traffic. Each cycle it may receive one packet event: a valid strobe, the packet's byte length and one record word (for example a header digest) to be kept in a capture store. The byte lengths are added up over fixed measurement windows of `WIN_CYC` clock cycles. The default of 10,000 cycles gives 100 µs at a 100 MHz clock. As soon as the running total inside the current window goes past a programmable threshold, a burst is declared. The block then emits a one-cycle pulse and increments a running burst count.

Record words are written into an external ring memory of `2**ADDR_W` entries all the time, one entry per packet at consecutive wrapping addresses, so the oldest entries are overwritten. When a burst is declared, writing goes on for a programmable number of further packets. The ring then stops taking writes, so it holds the packets that came before the burst, the packet that set it off, and the packets that followed it. The address of the triggering packet is held, so a reader can put the frozen ring back in time order. A re-arm strobe releases the ring. To stop one long surge from being counted many times, detection is disarmed after it fires. It is armed again only after a whole window closes with a total at or below the threshold.

Top module: `burst_capture_ctrl`

## Requirements
- R1: Byte lengths are summed over back-to-back windows of `WIN_CYC` cycles; the first window starts on the first cycle after reset, and the sum restarts at zero in each window. A burst is detected on the cycle a valid packet brings the sum of the current window, that packet included, strictly above `cfg_thresh`. `burst_pulse` is high for exactly the one cycle after that packet.
- R2: `burst_count` increases by exactly one for each detected burst and changes at no other time. It is updated on the same cycle that `burst_pulse` is high.
- R3: Once a burst has been detected, no new burst is detected until a complete window has closed with a total at or below `cfg_thresh`. Bursts are counted even while the ring is frozen.
- R4: Each accepted packet shows up one cycle later with `ring_we` high, `ring_wdata` equal to its record word and `ring_waddr` one above the previous write address, modulo `2**ADDR_W`. The first write after reset uses address 0.
- R5: After the triggering packet has been written, exactly `cfg_post` more packets are written. `frozen` rises on the cycle of the last of these writes, or on the trigger write itself when `cfg_post` is 0. While frozen, no packet is written.
- R6: `trig_ptr` holds the ring address of the packet that triggered the capture, and it stays steady while frozen.
- R7: A `rearm` pulse while frozen clears `frozen` one cycle later, and writing resumes at the address after the last write. A `rearm` at any other time has no effect. A burst detected during the post-trigger phase or while frozen does not restart the capture.
- R8: A packet can be accepted on every clock cycle, back to back, with no stall, so one packet per cycle is written.
- R9: After reset `burst_count`, `burst_pulse`, `ring_we`, `frozen` and `trig_ptr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One packet event this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_data | input | DATA_W | Record word to store for this packet |
| cfg_thresh | input | LEN_W+$clog2(WIN_CYC+1) | Byte threshold per window |
| cfg_post | input | ADDR_W | Packets written after the trigger packet |
| rearm | input | 1 | Release the frozen ring |
| burst_pulse | output | 1 | One-cycle burst indication |
| burst_count | output | CNT_W | Running number of bursts |
| ring_we | output | 1 | Ring write enable |
| ring_waddr | output | ADDR_W | Ring write address |
| ring_wdata | output | DATA_W | Ring write data |
| frozen | output | 1 | Ring holds a finished capture |
| trig_ptr | output | ADDR_W | Ring address of the triggering packet |

## Verification
The bench builds the block with `WIN_CYC`=50 and `ADDR_W`=4, so a 16-entry ring and a 50-cycle window. With these values the write address wraps several times in one run. A single burst's pre-trigger history overwrites the whole ring, and the hysteresis case of an over-threshold window followed by another over-threshold window, then a quiet one, fits in a few hundred cycles. With 116-byte packets against a threshold of 300, the third packet in a window triggers. That puts the boundary between "equal or below" and "strictly above" right next to the triggering packet.

// File: rtl/bmc_pkg.sv
`timescale 1ns/1ps
package bmc_pkg;

  // Capture phase of the ring controller
  typedef enum logic [1:0] {
    CAP_RUN  = 2'd0,   // writing continuously
    CAP_POST = 2'd1,   // writing the post-trigger tail
    CAP_HOLD = 2'd2    // frozen, waiting for re-arm
  } cap_state_e;

  // Width of a byte sum that cannot overflow within one window
  function automatic int sum_width(input int len_w, input int win_cyc);
    return len_w + $clog2(win_cyc + 1);
  endfunction

endpackage

// File: rtl/bmc_window.sv
`timescale 1ns/1ps
module bmc_window #(
  parameter int WIN_CYC = 10000,
  parameter int LEN_W   = 16,
  parameter int SUM_W   = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [SUM_W-1:0] cfg_thresh,
  output logic             over_now,
  output logic             quiet_close
);
  localparam int CW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0]    cyc_q;
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_next;
  logic             win_last;
  logic             above;

  always_comb begin
    acc_next    = acc_q + (pkt_valid ? SUM_W'(pkt_len) : '0);
    above       = acc_next > cfg_thresh;
    win_last    = (cyc_q == LAST);
    over_now    = pkt_valid && above;
    quiet_close = win_last && !above;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else if (win_last) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      acc_q <= acc_next;
    end
  end
endmodule

// File: rtl/bmc_trigger.sv
`timescale 1ns/1ps
module bmc_trigger #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             over_now,
  input  logic             quiet_close,
  output logic             fire,
  output logic             burst_pulse,
  output logic [CNT_W-1:0] burst_count
);
  logic armed_q;

  assign fire = armed_q && over_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b1;
      burst_pulse <= 1'b0;
      burst_count <= '0;
    end else begin
      burst_pulse <= fire;
      if (fire) begin
        armed_q     <= 1'b0;
        burst_count <= burst_count + 1'b1;
      end else if (quiet_close) begin
        armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bmc_ring_ctrl.sv
`timescale 1ns/1ps
module bmc_ring_ctrl
  import bmc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_valid,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              fire,
  input  logic [ADDR_W-1:0] cfg_post,
  input  logic              rearm,
  output logic              ring_we,
  output logic [ADDR_W-1:0] ring_waddr,
  output logic [DATA_W-1:0] ring_wdata,
  output logic              frozen,
  output logic [ADDR_W-1:0] trig_ptr
);
  cap_state_e        st_q;
  logic [ADDR_W-1:0] wp_q;
  logic [ADDR_W-1:0] left_q;
  logic              accept;

  assign accept = pkt_valid && (st_q != CAP_HOLD);
  assign frozen = (st_q == CAP_HOLD);

  // Write port toward the ring memory
  always_ff @(posedge clk) begin
    if (rst) begin
      ring_we    <= 1'b0;
      ring_waddr <= '0;
      ring_wdata <= '0;
      wp_q       <= '0;
    end else begin
      ring_we <= accept;
      if (accept) begin
        ring_waddr <= wp_q;
        ring_wdata <= pkt_data;
        wp_q       <= wp_q + 1'b1;
      end
    end
  end

  // Capture phase sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= CAP_RUN;
      left_q   <= '0;
      trig_ptr <= '0;
    end else begin
      unique case (st_q)
        CAP_RUN: begin
          if (fire) begin
            trig_ptr <= wp_q;
            if (cfg_post == '0) begin
              st_q <= CAP_HOLD;
            end else begin
              left_q <= cfg_post;
              st_q   <= CAP_POST;
            end
          end
        end
        CAP_POST: begin
          if (pkt_valid) begin
            left_q <= left_q - 1'b1;
            if (left_q == ADDR_W'(1)) st_q <= CAP_HOLD;
          end
        end
        CAP_HOLD: begin
          if (rearm) st_q <= CAP_RUN;
        end
        default: st_q <= CAP_RUN;
      endcase
    end
  end
endmodule

// File: rtl/burst_capture_ctrl.sv
`timescale 1ns/1ps
module burst_capture_ctrl #(
  parameter int WIN_CYC = 10000,
  parameter int LEN_W   = 16,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  pkt_valid,
  input  logic [LEN_W-1:0]                      pkt_len,
  input  logic [DATA_W-1:0]                     pkt_data,
  input  logic [LEN_W+$clog2(WIN_CYC+1)-1:0]    cfg_thresh,
  input  logic [ADDR_W-1:0]                     cfg_post,
  input  logic                                  rearm,
  output logic                                  burst_pulse,
  output logic [CNT_W-1:0]                      burst_count,
  output logic                                  ring_we,
  output logic [ADDR_W-1:0]                     ring_waddr,
  output logic [DATA_W-1:0]                     ring_wdata,
  output logic                                  frozen,
  output logic [ADDR_W-1:0]                     trig_ptr
);
  localparam int SUM_W = bmc_pkg::sum_width(LEN_W, WIN_CYC);

  logic over_now;
  logic quiet_close;
  logic fire;

  bmc_window #(.WIN_CYC(WIN_CYC), .LEN_W(LEN_W), .SUM_W(SUM_W)) u_window (
    .clk        (clk),
    .rst        (rst),
    .pkt_valid  (pkt_valid),
    .pkt_len    (pkt_len),
    .cfg_thresh (cfg_thresh),
    .over_now   (over_now),
    .quiet_close(quiet_close)
  );

  bmc_trigger #(.CNT_W(CNT_W)) u_trigger (
    .clk        (clk),
    .rst        (rst),
    .over_now   (over_now),
    .quiet_close(quiet_close),
    .fire       (fire),
    .burst_pulse(burst_pulse),
    .burst_count(burst_count)
  );

  bmc_ring_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data),
    .fire      (fire),
    .cfg_post  (cfg_post),
    .rearm     (rearm),
    .ring_we   (ring_we),
    .ring_waddr(ring_waddr),
    .ring_wdata(ring_wdata),
    .frozen    (frozen),
    .trig_ptr  (trig_ptr)
  );
endmodule

// File: rtl/bmc_checker.sv
`timescale 1ns/1ps
module bmc_checker #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rearm,
  input logic              burst_pulse,
  input logic [CNT_W-1:0]  burst_count,
  input logic              ring_we,
  input logic [ADDR_W-1:0] ring_waddr,
  input logic              frozen,
  input logic [ADDR_W-1:0] trig_ptr
);
  logic              seen_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (ring_we) begin
      seen_q <= 1'b1;
      prev_q <= ring_waddr;
    end
  end

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    burst_pulse |-> burst_count == $past(burst_count) + 1'b1);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !burst_pulse |-> burst_count == $past(burst_count));

  a_r3_no_repeat: assert property (@(posedge clk) disable iff (rst)
    burst_pulse |=> !burst_pulse);

  a_r4_addr_seq: assert property (@(posedge clk) disable iff (rst)
    (ring_we && seen_q) |-> ring_waddr == prev_q + 1'b1);

  a_r5_no_write_frozen: assert property (@(posedge clk) disable iff (rst)
    (frozen && $past(frozen)) |-> !ring_we);

  a_r5_freeze_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen) |-> ring_we);

  a_r6_trig_steady: assert property (@(posedge clk) disable iff (rst)
    (frozen && $past(frozen)) |-> $stable(trig_ptr));

  a_r7_release_by_rearm: assert property (@(posedge clk) disable iff (rst)
    $fell(frozen) |-> $past(rearm));
endmodule

bind burst_capture_ctrl bmc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rearm      (rearm),
  .burst_pulse(burst_pulse),
  .burst_count(burst_count),
  .ring_we    (ring_we),
  .ring_waddr (ring_waddr),
  .frozen     (frozen),
  .trig_ptr   (trig_ptr)
);

// File: tb/burst_capture_ctrl_test.sv
`timescale 1ns/1ps
module burst_capture_ctrl_test;
  localparam int WIN    = 50;
  localparam int LEN_W  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CNT_W  = 16;
  localparam int SUM_W  = LEN_W + $clog2(WIN + 1);
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_valid = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [DATA_W-1:0] pkt_data = '0;
  logic [SUM_W-1:0] cfg_thresh = SUM_W'(300);
  logic [ADDR_W-1:0] cfg_post = ADDR_W'(3);
  logic rearm = 1'b0;
  logic burst_pulse;
  logic [CNT_W-1:0] burst_count;
  logic ring_we;
  logic [ADDR_W-1:0] ring_waddr;
  logic [DATA_W-1:0] ring_wdata;
  logic frozen;
  logic [ADDR_W-1:0] trig_ptr;

  burst_capture_ctrl #(.WIN_CYC(WIN), .LEN_W(LEN_W), .DATA_W(DATA_W),
                       .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_data(pkt_data), .cfg_thresh(cfg_thresh), .cfg_post(cfg_post),
    .rearm(rearm), .burst_pulse(burst_pulse), .burst_count(burst_count),
    .ring_we(ring_we), .ring_waddr(ring_waddr), .ring_wdata(ring_wdata),
    .frozen(frozen), .trig_ptr(trig_ptr));

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int writes = 0;
  bit done   = 1'b0;

  typedef struct {
    bit we; int addr; int data; bit pulse; int count; bit frz; int trig;
  } exp_t;
  exp_t q[$];

  // Reference state built from the requirements
  int  m_cyc = 0, m_acc = 0, m_wp = 0, m_left = 0, m_trig = 0, m_count = 0, m_st = 0;
  bit  m_armed = 1'b1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(bit v, int len, int d, bit ra);
    exp_t e;
    int add, wp0;
    bit over, fire, last, acc_ok;
    pkt_valid = v; pkt_len = LEN_W'(len); pkt_data = DATA_W'(d); rearm = ra;
    add    = m_acc + (v ? len : 0);
    over   = v && (add > int'(cfg_thresh));
    fire   = m_armed && over;
    last   = (m_cyc == WIN - 1);
    acc_ok = v && (m_st != 2);
    wp0    = m_wp;
    e.we = acc_ok; e.addr = wp0; e.data = d;
    if (acc_ok) m_wp = (m_wp + 1) % DEPTH;
    case (m_st)
      0: if (fire) begin
           m_trig = wp0;
           if (cfg_post == 0) m_st = 2;
           else begin m_left = int'(cfg_post); m_st = 1; end
         end
      1: if (v) begin
           if (m_left == 1) m_st = 2;
           m_left--;
         end
      default: if (ra) m_st = 0;
    endcase
    if (fire) m_armed = 1'b0;
    else if (last && !(add > int'(cfg_thresh))) m_armed = 1'b1;
    if (last) begin m_cyc = 0; m_acc = 0; end
    else begin m_cyc++; m_acc = add; end
    if (fire) m_count++;
    e.pulse = fire; e.count = m_count; e.frz = (m_st == 2); e.trig = m_trig;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0);
  endtask

  // Monitor: compare the design against the queued expectations
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R5 write enable", int'(ring_we), int'(e.we));
      if (e.we && ring_we) begin
        writes++;
        chk("R4 write address", int'(ring_waddr), e.addr);
        chk("R4 write data", int'(ring_wdata), e.data);
      end
      chk("R1 burst pulse", int'(burst_pulse), int'(e.pulse));
      chk("R2 burst count", int'(burst_count), e.count);
      chk("R5 frozen", int'(frozen), int'(e.frz));
      chk("R6 trigger pointer", int'(trig_ptr), e.trig);
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 count", int'(burst_count), 0);
    chk("R9 pulse", int'(burst_pulse), 0);
    chk("R9 we", int'(ring_we), 0);
    chk("R9 frozen", int'(frozen), 0);
    chk("R9 trig", int'(trig_ptr), 0);
    rst = 1'b0;

    // Quiet traffic, one packet every cycle: 250 bytes per window
    w0 = writes;
    for (int i = 0; i < 60; i++) step(1'b1, 5, 32'h100 + i, 1'b0);
    step(1'b0, 0, 0, 1'b0);
    chk("R8 back-to-back writes", writes - w0, 60);
    chk("R1 no burst below threshold", int'(burst_count), 0);
    idle(39);

    // Burst: third 116-byte packet passes 300
    step(1'b1, 116, 32'hA0, 1'b0);
    step(1'b1, 116, 32'hA1, 1'b0);
    chk("R1 no pulse at 232 bytes", int'(burst_pulse), 0);
    step(1'b1, 116, 32'hA2, 1'b0);
    chk("R1 pulse above threshold", int'(burst_pulse), 1);
    for (int i = 3; i < 8; i++) step(1'b1, 116, 32'hA0 + i, 1'b0);
    chk("R2 one burst counted", int'(burst_count), 1);
    chk("R6 trigger address", int'(trig_ptr), 14);
    chk("R5 frozen after tail", int'(frozen), 1);

    // Hysteresis: next window is also heavy, must not count
    idle(42);
    for (int i = 0; i < 5; i++) step(1'b1, 116, 32'hB0 + i, 1'b0);
    chk("R3 no recount while disarmed", int'(burst_count), 1);
    chk("R5 no write while frozen", int'(ring_we), 0);
    idle(45);
    idle(50);
    chk("R5 still frozen", int'(frozen), 1);

    // Re-arm, then resume writing after the last written address
    step(1'b0, 0, 0, 1'b1);
    chk("R7 rearm releases", int'(frozen), 0);
    step(1'b1, 116, 32'hC0, 1'b0);
    chk("R7 resume address", int'(ring_waddr), 2);
    step(1'b1, 116, 32'hC1, 1'b1);
    chk("R7 rearm ignored when running", int'(frozen), 0);
    chk("R7 next address", int'(ring_waddr), 3);

    // Zero tail length: freeze on the trigger write
    cfg_post = '0;
    step(1'b1, 116, 32'hC2, 1'b0);
    chk("R3 rearmed after quiet window", int'(burst_count), 2);
    chk("R5 freeze on trigger write", int'(frozen), 1);
    chk("R6 trigger at address 4", int'(trig_ptr), 4);
    step(1'b1, 116, 32'hC3, 1'b0);
    chk("R5 frozen blocks write", int'(ring_we), 0);
    idle(3);
    chk("R4 all expectations consumed", q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule